// File: doc/BRIEF.md
# Programmable I2C Master Engine

This block runs I2C master transactions on request from a command decoder. One request names an address byte (seven address bits and the direction bit in bit 0), a count of data bytes and whether the bus is kept at the end. The engine issues a START, sends the address, then writes or reads the counted bytes, and ends with a STOP. If the bus is kept, the engine ends with SCL held low and no STOP. The next request then begins with a repeated START. The lines are open-drain: the engine only pulls SCL or SDA low through output enables and reads the wire levels back.

The SCL low and high phases each take a number of reference clocks set at the inputs, so the bit rate is the reference clock divided by their sum. SDA moves only in the middle of the low phase. A released SCL that another device holds low pauses the high phase. If it stays low past a set limit, the engine gives up. The engine also watches for a lost arbitration and reports a two-bit status code with a one-cycle completion pulse.

Top module: `i2c_master_engine`

## Requirements
- R1: After reset both output enables are 0, `busy` is 0 and `done` is 0.
- R2: With no stretching by other devices, every SCL low phase lasts `cfg_lo` clocks and every SCL high phase inside a byte lasts `cfg_hi` clocks, so one bit takes `cfg_lo + cfg_hi` clocks.
- R3: While SCL is low, `sda_oe` changes only at the midpoint of the low phase, between `cfg_lo/2` and `cfg_lo/2 + 2` clocks after SCL falls. While SCL is high, SDA changes only to form a START (falling) or a STOP (rising), and it stays unchanged during every data or acknowledge high phase.
- R4: A write (`go_addr[0]` = 0) sends the address byte and then `go_len` bytes, most significant bit first. `wr_take` pulses once as each data byte is loaded from `wr_data`. The transfer ends with a STOP and status 2'b00 (OK).
- R5: A read (`go_addr[0]` = 1) returns `go_len` bytes through one-cycle `rd_valid` pulses. The engine acknowledges every byte except the last, which it leaves unacknowledged before the STOP.
- R6: If the address byte is not acknowledged, the engine sends a STOP, loads no data byte (no `wr_take`) and reports status 2'b01.
- R7: If a written data byte is not acknowledged, the remaining bytes are dropped, a STOP follows and the status is 2'b10.
- R8: With `go_keep` = 1, the transfer completes with no STOP and SCL held low while idle. The next `go` produces a repeated START: SDA is released while SCL is low, then falls while SCL is high.
- R9: If SDA reads low at the sampling point of a bit the engine leaves released while transmitting, it releases both lines, pulses `done` and sets `arb_lost`. No STOP is sent.
- R10: A high phase counts only while SCL reads high, so a short hold-low by another device stretches the bit and the transfer still succeeds. If released SCL reads low for more than `cfg_tmo` consecutive clocks, the engine releases both lines and reports status 2'b11.
- R11: `done` is high for exactly one clock per request. A `go` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hi | input | CNT_W | SCL high phase length in clocks (at least 2) |
| cfg_lo | input | CNT_W | SCL low phase length in clocks (at least 2) |
| cfg_tmo | input | CNT_W | Limit on SCL held low by others, in clocks |
| go | input | 1 | Request strobe, taken when idle |
| go_addr | input | 8 | Address byte; bit 0 = 1 selects read |
| go_len | input | LEN_W | Number of data bytes |
| go_keep | input | 1 | Keep the bus at the end (no STOP) |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Pulse: `wr_data` was loaded |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | Pulse: `rd_data` is new |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 OK, 01 address NACK, 10 data NACK, 11 timeout |
| arb_lost | output | 1 | Arbitration was lost (valid with `done`) |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Some properties are checked on every cycle. SDA stays unchanged through each high phase and `done` never lasts two cycles. A timeout leads straight to a completion with code 11, a lost arbitration leaves both lines released, and the byte strobes match the direction. Other properties only show at the wire level in the bench's scenarios. These are the exact phase lengths, the midpoint placement of SDA and the acknowledge pattern of reads. They also include the byte counts after address and data NACKs, the repeated START with no STOP between, and tolerance of a short SCL stretch. A small slave model on the open-drain wires gives that view.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic [1:0] {
        XS_OK        = 2'b00,
        XS_ADDR_NACK = 2'b01,
        XS_DATA_NACK = 2'b10,
        XS_TIMEOUT   = 2'b11
    } xfer_status_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RSLO,
        PH_SETUP,
        PH_HOLD,
        PH_LO,
        PH_HI,
        PH_PLO,
        PH_PHI,
        PH_PEND
    } phase_e;

    // Phases in which SCL is released and the engine waits for it to read high
    function automatic logic is_wait_phase(input phase_e p);
        return (p == PH_SETUP) || (p == PH_HI) || (p == PH_PHI);
    endfunction

    // Phases in which the engine pulls SCL low
    function automatic logic is_low_phase(input phase_e p);
        return (p == PH_RSLO) || (p == PH_LO) || (p == PH_PLO);
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             mid,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (run)       cnt <= cnt + 1'b1;
    end

    assign mid  = run && (cnt == (len >> 1));
    assign last = run && (cnt == len - 1'b1);
endmodule

// File: rtl/i2c_low_guard.sv
module i2c_low_guard #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             watch,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic             held;
    logic [CNT_W-1:0] cnt;

    assign held = watch && !scl_in;

    always_ff @(posedge clk) begin
        if (rst || !held)       cnt <= '0;
        else if (cnt != limit)  cnt <= cnt + 1'b1;
    end

    assign expired = held && (cnt == limit);

    // R10: the window never runs past its limit
    a_r10_guard_bounded: assert property (@(posedge clk) disable iff (rst)
        (held && $past(held) && $stable(limit)) |-> (cnt <= limit));
endmodule

// File: rtl/i2c_master_engine.sv
module i2c_master_engine
    import i2c_eng_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_hi,
    input  logic [CNT_W-1:0] cfg_lo,
    input  logic [CNT_W-1:0] cfg_tmo,
    input  logic             go,
    input  logic [7:0]       go_addr,
    input  logic [LEN_W-1:0] go_len,
    input  logic             go_keep,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic             arb_lost,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam logic [3:0] ACK_BIT = 4'd8;
    localparam logic [7:0] RD_FILL = 8'hFF;

    phase_e           phase, nxt;
    logic [7:0]       sh, rd_q;
    logic [3:0]       bitn;
    logic [LEN_W-1:0] left;
    logic             in_addr, rd_mode, keep_q, held;
    logic             sda_q, done_q, arb_q, rdv_q, take_q;
    xfer_status_e     stat_q;

    logic             run, tm_mid, tm_last, tmo, restart;
    logic [CNT_W-1:0] ph_len;
    logic             tx_byte, sample, ack_slot, arb_hit, nack;

    assign tx_byte  = in_addr || !rd_mode;
    assign sample   = (phase == PH_HI) && tm_last;
    assign ack_slot = (bitn == ACK_BIT);
    assign arb_hit  = sample && !ack_slot && tx_byte && sh[7] && !sda_in;
    assign nack     = sample && ack_slot && tx_byte && sda_in;

    always_comb begin
        run    = 1'b1;
        ph_len = cfg_hi;
        case (phase)
            PH_IDLE:                   run    = 1'b0;
            PH_RSLO, PH_LO, PH_PLO:    ph_len = cfg_lo;
            PH_SETUP, PH_HI, PH_PHI:   run    = scl_in;
            default: ;
        endcase
    end

    i2c_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .run(run),
        .len(ph_len), .mid(tm_mid), .last(tm_last)
    );

    i2c_low_guard #(.CNT_W(CNT_W)) u_guard (
        .clk(clk), .rst(rst), .watch(is_wait_phase(phase)),
        .scl_in(scl_in), .limit(cfg_tmo), .expired(tmo)
    );

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE:  if (go)      nxt = held ? PH_RSLO : PH_SETUP;
            PH_RSLO:  if (tm_last) nxt = PH_SETUP;
            PH_SETUP: if (tm_last) nxt = PH_HOLD;
            PH_HOLD:  if (tm_last) nxt = PH_LO;
            PH_LO:    if (tm_last) nxt = PH_HI;
            PH_HI: begin
                if (arb_hit)                nxt = PH_IDLE;
                else if (tm_last) begin
                    if (!ack_slot)          nxt = PH_LO;
                    else if (nack)          nxt = PH_PLO;
                    else if (left != '0)    nxt = PH_LO;
                    else if (keep_q)        nxt = PH_IDLE;
                    else                    nxt = PH_PLO;
                end
            end
            PH_PLO:   if (tm_last) nxt = PH_PHI;
            PH_PHI:   if (tm_last) nxt = PH_PEND;
            PH_PEND:  if (tm_last) nxt = PH_IDLE;
            default:               nxt = PH_IDLE;
        endcase
        if (tmo) nxt = PH_IDLE;
    end

    assign restart = (nxt != phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            sh      <= '0;
            rd_q    <= '0;
            bitn    <= '0;
            left    <= '0;
            in_addr <= 1'b0;
            rd_mode <= 1'b0;
            keep_q  <= 1'b0;
            held    <= 1'b0;
            sda_q   <= 1'b0;
            done_q  <= 1'b0;
            arb_q   <= 1'b0;
            rdv_q   <= 1'b0;
            take_q  <= 1'b0;
            stat_q  <= XS_OK;
        end else begin
            phase  <= nxt;
            done_q <= (phase != PH_IDLE) && (nxt == PH_IDLE);
            rdv_q  <= 1'b0;
            take_q <= 1'b0;
            case (phase)
                PH_IDLE: if (go) begin
                    sh      <= go_addr;
                    bitn    <= '0;
                    left    <= go_len;
                    in_addr <= 1'b1;
                    rd_mode <= go_addr[0];
                    keep_q  <= go_keep;
                    stat_q  <= XS_OK;
                    arb_q   <= 1'b0;
                end
                PH_RSLO:  if (tm_mid)  sda_q <= 1'b0;
                PH_SETUP: if (tm_last) sda_q <= 1'b1;
                PH_LO: if (tm_mid) begin
                    if (!ack_slot) sda_q <= !sh[7];
                    else           sda_q <= !in_addr && rd_mode && (left != '0);
                end
                PH_HI: begin
                    if (sample && !ack_slot) begin
                        sh   <= {sh[6:0], sda_in};
                        bitn <= bitn + 1'b1;
                    end else if (sample) begin
                        bitn <= '0;
                        if (!tx_byte) begin
                            rd_q  <= sh;
                            rdv_q <= 1'b1;
                        end
                        if (nack) begin
                            stat_q <= in_addr ? XS_ADDR_NACK : XS_DATA_NACK;
                        end else if (left != '0) begin
                            in_addr <= 1'b0;
                            left    <= left - 1'b1;
                            sh      <= rd_mode ? RD_FILL : wr_data;
                            take_q  <= !rd_mode;
                        end else begin
                            held <= keep_q;
                        end
                    end
                    if (arb_hit) begin
                        arb_q <= 1'b1;
                        sda_q <= 1'b0;
                        held  <= 1'b0;
                    end
                end
                PH_PLO:  if (tm_mid)  sda_q <= 1'b1;
                PH_PHI:  if (tm_last) sda_q <= 1'b0;
                PH_PEND: if (tm_last) held  <= 1'b0;
                default: ;
            endcase
            if (tmo) begin
                stat_q <= XS_TIMEOUT;
                sda_q  <= 1'b0;
                held   <= 1'b0;
            end
        end
    end

    assign scl_oe   = is_low_phase(phase) || ((phase == PH_IDLE) && held);
    assign sda_oe   = sda_q;
    assign busy     = (phase != PH_IDLE);
    assign done     = done_q;
    assign status   = stat_q;
    assign arb_lost = arb_q;
    assign rd_data  = rd_q;
    assign rd_valid = rdv_q;
    assign wr_take  = take_q;

    // R3: SDA does not move while a bit's high phase lasts
    a_r3_sda_still_in_high: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI && $past(phase) == PH_HI) |-> $stable(sda_oe));

    // R11: completion is a single-cycle pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: after a lost arbitration both lines are free
    a_r9_arb_releases: assert property (@(posedge clk) disable iff (rst)
        (done && arb_lost) |-> (!scl_oe && !sda_oe));

    // R10: an expired guard ends the request with the timeout code
    a_r10_timeout_reported: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (done && status == XS_TIMEOUT && !scl_oe && !sda_oe));

    // R4: write bytes are only loaded in write direction
    a_r4_take_in_write: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> (!rd_mode && busy));

    // R5: read bytes are only delivered in read direction
    a_r5_rdv_in_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_mode);
endmodule

// File: tb/i2c_master_engine_tb.sv
module i2c_master_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HI  = 6;
    localparam int LO  = 10;
    localparam int TMO = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] cfg_hi = 16'(HI), cfg_lo = 16'(LO), cfg_tmo = 16'(TMO);
    logic        go = 1'b0, go_keep = 1'b0;
    logic [7:0]  go_addr = '0, go_len = '0;
    logic [7:0]  wr_data, rd_data;
    logic        wr_take, rd_valid, busy, done, arb_lost, scl_oe, sda_oe;
    logic [1:0]  status;
    logic        slv_sda_low = 1'b0, slv_scl_low = 1'b0, other_sda = 1'b0;
    logic        scl_w, sda_w;

    assign scl_w = !(scl_oe || slv_scl_low);
    assign sda_w = !(sda_oe || slv_sda_low || other_sda);

    logic [7:0] wr_src [0:15];
    logic [7:0] rd_src [0:15];
    logic [7:0] wr_got [0:15];
    logic [7:0] rd_got [0:15];
    int widx = 0, ntake = 0, nrd = 0;
    assign wr_data = wr_src[widx];

    i2c_master_engine u_dut (
        .clk(clk), .rst(rst), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_tmo(cfg_tmo),
        .go(go), .go_addr(go_addr), .go_len(go_len), .go_keep(go_keep),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .status(status), .arb_lost(arb_lost),
        .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (wr_take) begin widx <= widx + 1; ntake <= ntake + 1; end
        if (rd_valid) begin rd_got[nrd] = rd_data; nrd <= nrd + 1; end
    end

    // Slave model on the wires
    int   slv_addr = 7'h50, slv_nack_at = -1;
    bit   slv_nack_addr = 0;
    bit   p_scl = 1, p_sda = 1, s_act = 0, s_in_addr = 0, s_rd = 0, s_mnack = 0, s_addr_ok = 0;
    int   s_bc = 0, n_start = 0, n_stop = 0, n_wr = 0, m_ack = 0, rd_idx = 0;
    logic [7:0] s_sh = '0, s_tx = '0, s_got_addr = '0;

    always @(posedge clk) begin
        if (p_scl && scl_w && p_sda && !sda_w) begin
            n_start++; s_act = 1; s_bc = 0; s_in_addr = 1; s_rd = 0; s_mnack = 0;
            slv_sda_low <= 1'b0;
        end else if (p_scl && scl_w && !p_sda && sda_w) begin
            n_stop++; s_act = 0; slv_sda_low <= 1'b0;
        end else if (s_act && !p_scl && scl_w) begin
            if (s_bc < 8) s_sh = {s_sh[6:0], sda_w};
            else if (s_rd) begin if (sda_w) s_mnack = 1; else m_ack++; end
            s_bc++;
        end else if (s_act && p_scl && !scl_w) begin
            if (s_bc == 8) begin
                if (s_in_addr) begin
                    s_addr_ok  = (int'(s_sh[7:1]) == slv_addr) && !slv_nack_addr;
                    s_got_addr = s_sh;
                    slv_sda_low <= s_addr_ok;
                end else if (!s_rd) begin
                    wr_got[n_wr] = s_sh;
                    slv_sda_low <= (n_wr != slv_nack_at);
                    n_wr++;
                end else slv_sda_low <= 1'b0;
            end else if (s_bc == 9) begin
                s_bc = 0;
                if (s_in_addr) begin s_in_addr = 0; s_rd = s_addr_ok && s_got_addr[0]; end
                if (s_rd && !s_mnack) begin
                    s_tx = rd_src[rd_idx]; rd_idx++;
                    slv_sda_low <= !s_tx[7];
                end else slv_sda_low <= 1'b0;
            end else if (s_bc >= 1 && s_bc <= 7 && s_rd && !s_mnack) begin
                slv_sda_low <= !s_tx[7 - s_bc];
            end
        end
        p_scl = scl_w; p_sda = sda_w;
    end

    // Wire timing monitor, sampled between edges
    int  lowcnt = 0, highcnt = 0, n_bad_low = 0, n_bad_high = 0, n_bad_mid = 0, n_fall = 0;
    bit  pm_scl = 1, pm_oe = 0, saw_low = 0;
    always @(negedge clk) begin
        if (scl_w) begin
            if (!pm_scl) begin
                if (lowcnt != LO) n_bad_low++;
                highcnt = 0; saw_low = 1;
            end
            highcnt++;
        end else begin
            if (pm_scl) begin
                n_fall++;
                if (saw_low && highcnt != HI) n_bad_high++;
                lowcnt = 0;
            end
            lowcnt++;
        end
        if (!scl_w && sda_oe != pm_oe && (lowcnt < LO/2 || lowcnt > LO/2 + 2)) n_bad_mid++;
        pm_scl = scl_w; pm_oe = sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 180000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    int res_status, res_arb, res_cycles, res_done;

    task automatic clr(input int addr7, input bit nack_addr, input int nack_at);
        @(negedge clk);
        slv_addr = addr7; slv_nack_addr = nack_addr; slv_nack_at = nack_at;
        n_start = 0; n_stop = 0; n_wr = 0; m_ack = 0; rd_idx = 0;
        widx = 0; ntake = 0; nrd = 0;
        n_bad_low = 0; n_bad_high = 0; n_bad_mid = 0; n_fall = 0; saw_low = 0;
    endtask

    task automatic kick(input logic [7:0] addr, input int len, input bit keep);
        @(negedge clk);
        go = 1'b1; go_addr = addr; go_len = 8'(len); go_keep = keep;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int c = 0;
        res_done = 0;
        while (c < 20000) begin
            if (done) begin res_done = 1; break; end
            @(negedge clk); c++;
        end
        res_cycles = c; res_status = int'(status); res_arb = int'(arb_lost);
        chk(res_done == 1, {tag, " done seen"}, res_done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R11 done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(!scl_oe && !sda_oe, "R1 lines released after reset", int'({scl_oe, sda_oe}), 0);
        chk(!busy, "R1 not busy after reset", int'(busy), 0);
        chk(!done, "R1 no done after reset", int'(done), 0);
    endtask

    task automatic t_write();
        wr_src[0] = 8'hA5; wr_src[1] = 8'h3C; wr_src[2] = 8'hFF;
        clr(7'h50, 0, -1);
        kick(8'hA0, 3, 0);
        repeat (100) @(negedge clk);
        go = 1'b1; go_addr = 8'h12; @(negedge clk); go = 1'b0;   // R11: ignored while busy
        wait_done("R4");
        chk(res_status == 0, "R4 write status OK", res_status, 0);
        chk(n_wr == 3, "R4 bytes received", n_wr, 3);
        chk(wr_got[0] == 8'hA5 && wr_got[1] == 8'h3C && wr_got[2] == 8'hFF,
            "R4 byte values", int'(wr_got[1]), 8'h3C);
        chk(ntake == 3, "R4 wr_take count", ntake, 3);
        chk(int'(s_got_addr) == 8'hA0, "R4 address byte", int'(s_got_addr), 8'hA0);
        chk(n_start == 1 && n_stop == 1, "R11 busy go ignored, one START/STOP", n_start, 1);
        chk(n_bad_low == 0, "R2 low phase length", n_bad_low, 0);
        chk(n_bad_high == 0, "R2 high phase length", n_bad_high, 0);
        chk(n_bad_mid == 0, "R3 SDA moves at low midpoint", n_bad_mid, 0);
    endtask

    task automatic t_read();
        rd_src[0] = 8'h11; rd_src[1] = 8'hE7; rd_src[2] = 8'h80;
        clr(7'h50, 0, -1);
        kick(8'hA1, 3, 0);
        wait_done("R5");
        chk(res_status == 0, "R5 read status OK", res_status, 0);
        chk(nrd == 3, "R5 rd_valid count", nrd, 3);
        chk(rd_got[0] == 8'h11 && rd_got[1] == 8'hE7 && rd_got[2] == 8'h80,
            "R5 read values", int'(rd_got[1]), 8'hE7);
        chk(m_ack == 2 && s_mnack, "R5 ACK all but last", m_ack, 2);
        chk(n_stop == 1, "R5 STOP after read", n_stop, 1);
        chk(n_bad_mid == 0, "R3 midpoint in read", n_bad_mid, 0);
    endtask

    task automatic t_addr_nack();
        wr_src[0] = 8'h01; wr_src[1] = 8'h02;
        clr(7'h51, 0, -1);
        kick(8'hA0, 2, 0);
        wait_done("R6");
        chk(res_status == 1, "R6 address NACK code", res_status, 1);
        chk(ntake == 0, "R6 no byte loaded", ntake, 0);
        chk(n_wr == 0 && n_stop == 1, "R6 STOP, no data", n_wr, 0);
    endtask

    task automatic t_data_nack();
        wr_src[0] = 8'h10; wr_src[1] = 8'h20; wr_src[2] = 8'h30; wr_src[3] = 8'h40;
        clr(7'h50, 0, 1);
        kick(8'hA0, 4, 0);
        wait_done("R7");
        chk(res_status == 2, "R7 data NACK code", res_status, 2);
        chk(n_wr == 2, "R7 remaining bytes dropped", n_wr, 2);
        chk(ntake == 2, "R7 wr_take count", ntake, 2);
        chk(n_stop == 1, "R7 STOP after NACK", n_stop, 1);
    endtask

    task automatic t_restart();
        wr_src[0] = 8'h5A;
        rd_src[0] = 8'hC3; rd_src[1] = 8'h0F;
        clr(7'h50, 0, -1);
        kick(8'hA0, 1, 1);
        wait_done("R8");
        chk(res_status == 0 && n_stop == 0, "R8 kept bus has no STOP", n_stop, 0);
        repeat (20) @(negedge clk);
        chk(scl_oe && !busy, "R8 SCL held low while parked", int'(scl_oe), 1);
        kick(8'hA1, 2, 0);
        wait_done("R8");
        chk(n_start == 2 && n_stop == 1, "R8 repeated START then one STOP", n_start, 2);
        chk(nrd == 2 && rd_got[0] == 8'hC3 && rd_got[1] == 8'h0F,
            "R8 read after repeated START", int'(rd_got[0]), 8'hC3);
        chk(n_bad_mid == 0, "R3 midpoint around repeated START", n_bad_mid, 0);
    endtask

    task automatic t_arb();
        clr(7'h50, 0, -1);
        kick(8'hA0, 1, 0);
        wait (scl_oe == 1'b1);
        @(negedge clk);
        other_sda = 1'b1;
        wait_done("R9");
        chk(res_arb == 1, "R9 arbitration lost flag", res_arb, 1);
        chk(!scl_oe && !sda_oe, "R9 lines released", int'({scl_oe, sda_oe}), 0);
        chk(n_stop == 0 && ntake == 0, "R9 no STOP, no data", n_stop, 0);
        other_sda = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_stretch();
        wr_src[0] = 8'h77; wr_src[1] = 8'h88;
        clr(7'h50, 0, -1);
        kick(8'hA0, 2, 0);
        wait (n_fall == 10);
        @(negedge clk);
        slv_scl_low = 1'b1;
        repeat (50) @(negedge clk);
        slv_scl_low = 1'b0;
        wait_done("R10");
        chk(res_status == 0, "R10 short stretch tolerated", res_status, 0);
        chk(n_wr == 2 && wr_got[0] == 8'h77 && wr_got[1] == 8'h88,
            "R10 data intact after stretch", n_wr, 2);
    endtask

    task automatic t_timeout();
        clr(7'h50, 0, -1);
        slv_scl_low = 1'b1;
        kick(8'hA0, 1, 0);
        wait_done("R10");
        chk(res_status == 3, "R10 timeout code", res_status, 3);
        chk(res_cycles >= TMO - 2 && res_cycles <= TMO + 10, "R10 timeout delay", res_cycles, TMO);
        chk(!scl_oe && !sda_oe && !busy, "R10 lines released on timeout", int'({scl_oe, sda_oe}), 0);
        slv_scl_low = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_addr_nack();
        t_data_nack();
        t_restart();
        t_arb();
        t_stretch();
        t_timeout();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule